// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the slave-side protocol engine for a 256-byte memory reached over a two-wire I2C bus. It brings the bus clock and data lines into the system clock domain and detects START and STOP conditions. It then checks each address byte against a fixed 7-bit device identity. When the master writes, the first byte after the address loads a word pointer, and each byte after that is pushed to an external page buffer together with its target address. When the master reads, bytes are fetched through a simple combinational read port and shifted out MSB first.

The word pointer persists between transactions. This gives three read styles: a read with no address phase, a random read built from an address-only write followed by a repeated START, and a sequential read that runs across the whole array. When a STOP ends a transaction that carried data, the block pulses a commit strobe. While the external write cycle reports busy, the block does not acknowledge its own address, so a master can poll for completion. The bus data line is open-drain: the block only ever pulls it low, by asserting `sda_oe`.

Top module: `i2c_mem_slave`

## Requirements
- R1: A transfer begins only after a START (SDA falling while SCL is high). Bytes clocked in while idle with no preceding START get no acknowledge.
- R2: An address byte whose upper seven bits are 1010000 is acknowledged by pulling SDA low through the ninth SCL clock. Bit 0 of that byte selects the direction: 1 for read, 0 for write.
- R3: In a write transaction, every received byte after the address byte is acknowledged.
- R4: While `wr_busy` is high, a matching address byte gets no acknowledge.
- R5: In a write, the first byte loads the word pointer. Each later byte raises `wr_push` for one cycle, with `wr_addr` set to the pointer and `wr_data` set to the byte.
- R6: The pointer resets to 0. A read with no address phase returns the byte at the pointer, which is the last accessed address plus one.
- R7: A write that carries only a word address, followed by a repeated START and a read address byte, returns the byte at that word address.
- R8: During a read, each master acknowledge sends the next byte. The read pointer increments across all 8 bits and wraps from 255 to 0.
- R9: The write pointer increments only its low 4 bits, so writes wrap within a 16-byte page. `wr_commit` pulses once at a STOP that ends a transaction with at least one data byte, and not otherwise.
- R10: After an address mismatch, SDA is not driven for the rest of the transfer, until the next START.
- R11: If the master does not acknowledge a read byte, SDA is released and stays released until STOP.
- R12: A START received in the middle of a byte aborts the transfer, clears the bit count, and begins a new address phase.
- R13: `sda_oe` changes only while the synchronized SCL is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| mem_raddr | output | 8 | Read-port address (the word pointer) |
| mem_rdata | input | 8 | Read-port data, combinational from mem_raddr |
| wr_busy | input | 1 | External write cycle in progress |
| wr_push | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 8 | Target address of the pushed byte |
| wr_data | output | 8 | Pushed byte |
| wr_commit | output | 1 | One-cycle strobe at a STOP that ends a write with data |

## Verification
Each SCL or SDA edge reaches the controller's decision logic on the third system clock after it reaches the pad: two synchronizer flops, then one edge register. A registered `sda_oe` or a push strobe follows one cycle later, and `wr_commit` follows the STOP detection by one cycle. The bench holds each quarter of an SCL bit for eight clocks and samples the wired data line in the middle of the SCL high phase. That point lies well after every drive change and well before the next edge. The bench compares push strobes on every clock, in order, against a queue that its own pointer and page model predicts, and it checks read bytes against its own memory image, which is updated only at commit.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_ACK,
    ST_RDATA,
    ST_RMACK,
    ST_WSTOP
  } state_t;
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_ns = rs_q[1];
endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc_rd,
  input  logic              inc_wr,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [PAGE_W-1:0] low_inc;

  assign low_inc = ptr_q[PAGE_W-1:0] + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (ld)          ptr_d = ld_val;
    else if (inc_rd) ptr_d = ptr_q + 1'b1;
    else if (inc_wr) ptr_d = {ptr_q[ADDR_W-1:PAGE_W], low_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID      = 7'b1010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              wr_busy,
  output logic              wr_push,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic rst_ns;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_ns), .din(scl_i), .dout(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_ns), .din(sda_i), .dout(sda_s));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  state_t            state_q, state_d, ack_nxt_q, ack_nxt_d;
  logic [BIT_CW-1:0] bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [BYTE_W-1:0] waddr_q, waddr_d, wdata_q, wdata_d;
  logic              rx_done_q, rx_done_d, mack_q, mack_d;
  logic              oe_q, oe_d, wrote_q, wrote_d;
  logic              push_q, push_d, commit_q, commit_d;
  logic              ptr_ld, ptr_inc_rd, ptr_inc_wr;
  logic [BYTE_W-1:0] ptr;

  i2c_addr_ptr #(.ADDR_W(BYTE_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_ns), .ld(ptr_ld), .ld_val(rx_q),
    .inc_rd(ptr_inc_rd), .inc_wr(ptr_inc_wr), .ptr(ptr));

  always_comb begin
    state_d    = state_q;
    ack_nxt_d  = ack_nxt_q;
    bitcnt_d   = bitcnt_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    waddr_d    = waddr_q;
    wdata_d    = wdata_q;
    rx_done_d  = rx_done_q;
    mack_d     = mack_q;
    oe_d       = oe_q;
    wrote_d    = wrote_q;
    push_d     = 1'b0;
    commit_d   = 1'b0;
    ptr_ld     = 1'b0;
    ptr_inc_rd = 1'b0;
    ptr_inc_wr = 1'b0;

    if (stop_det) begin
      state_d   = ST_IDLE;
      oe_d      = 1'b0;
      commit_d  = wrote_q;
      wrote_d   = 1'b0;
      rx_done_d = 1'b0;
    end else if (start_det) begin
      state_d   = ST_DEV;
      bitcnt_d  = '0;
      oe_d      = 1'b0;
      rx_done_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise) begin
            rx_d     = {rx_q[BYTE_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
            if (bitcnt_q == LAST_BIT) rx_done_d = 1'b1;
          end else if (scl_fall && rx_done_q) begin
            rx_done_d = 1'b0;
            bitcnt_d  = '0;
            if (state_q == ST_DEV) begin
              if (rx_q[BYTE_W-1:1] == DEV_ID && !wr_busy) begin
                oe_d      = 1'b1;
                state_d   = ST_ACK;
                ack_nxt_d = rx_q[0] ? ST_RDATA : ST_WADR;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WADR) begin
              ptr_ld    = 1'b1;
              oe_d      = 1'b1;
              state_d   = ST_ACK;
              ack_nxt_d = ST_WDAT;
            end else begin
              push_d     = 1'b1;
              waddr_d    = ptr;
              wdata_d    = rx_q;
              ptr_inc_wr = 1'b1;
              wrote_d    = 1'b1;
              oe_d       = 1'b1;
              state_d    = ST_ACK;
              ack_nxt_d  = ST_WDAT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_d     = 1'b0;
            bitcnt_d = '0;
            state_d  = ack_nxt_q;
            if (ack_nxt_q == ST_RDATA) begin
              tx_d       = mem_rdata;
              oe_d       = ~mem_rdata[BYTE_W-1];
              ptr_inc_rd = 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == LAST_BIT) begin
              oe_d     = 1'b0;
              bitcnt_d = '0;
              state_d  = ST_RMACK;
            end else begin
              tx_d     = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d     = ~tx_q[BYTE_W-2];
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end
        end
        ST_RMACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d       = mem_rdata;
              oe_d       = ~mem_rdata[BYTE_W-1];
              ptr_inc_rd = 1'b1;
              state_d    = ST_RDATA;
            end else begin
              state_d = ST_WSTOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q   <= ST_IDLE;
      ack_nxt_q <= ST_IDLE;
      bitcnt_q  <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      rx_done_q <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      wrote_q   <= 1'b0;
      push_q    <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      ack_nxt_q <= ack_nxt_d;
      bitcnt_q  <= bitcnt_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      waddr_q   <= waddr_d;
      wdata_q   <= wdata_d;
      rx_done_q <= rx_done_d;
      mack_q    <= mack_d;
      oe_q      <= oe_d;
      wrote_q   <= wrote_d;
      push_q    <= push_d;
      commit_q  <= commit_d;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_raddr = ptr;
  assign wr_push   = push_q;
  assign wr_addr   = waddr_q;
  assign wr_data   = wdata_q;
  assign wr_commit = commit_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              wr_push,
  input logic              wr_commit,
  input logic              wr_busy,
  input logic              start_det,
  input logic              stop_det,
  input state_t            state,
  input logic [BIT_CW-1:0] bitcnt
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sda_oe) |-> !scl_s) else $error("oe rose with scl high"); // R13

  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_push |=> !wr_push) else $error("push longer than one cycle"); // R5

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_commit |-> $past(stop_det)) else $error("commit without stop"); // R9

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_ns)
    (state == ST_ACK && $past(state) == ST_DEV) |-> !$past(wr_busy))
    else $error("address acked while busy"); // R4

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_ns)
    (state == ST_IDLE) |-> !sda_oe) else $error("drive while idle"); // R10

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_ns)
    start_det |=> (state == ST_DEV && bitcnt == '0))
    else $error("start did not restart"); // R12
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_push(wr_push), .wr_commit(wr_commit), .wr_busy(wr_busy),
  .start_det(start_det), .stop_det(stop_det), .state(state_q),
  .bitcnt(bitcnt_q));

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int Q        = 8;
  localparam int BUSY_CYC = 600;

  logic clk, rst_n, scl, sda_m, sda_line;
  logic sda_oe, wr_busy, wr_push, wr_commit;
  logic [7:0] mem_raddr, mem_rdata, wr_addr, wr_data;

  logic [7:0]  mem [256];
  logic [15:0] exp_q[$];
  logic [15:0] pend_q[$];
  int busy_cnt, commits, n_chk, n_fail, eptr;

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_raddr];
  assign wr_busy   = (busy_cnt != 0);

  i2c_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .wr_busy(wr_busy),
    .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory image, write-cycle model, push comparison on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 7 + 3) % 256);
      busy_cnt <= 0;
      commits  <= 0;
    end else begin
      if (wr_push) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected push", {wr_addr, wr_data}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R5 push addr/data", {wr_addr, wr_data}, e);
        end
        pend_q.push_back({wr_addr, wr_data});
      end
      if (wr_commit) begin
        while (pend_q.size() > 0) begin
          logic [15:0] p;
          p = pend_q.pop_front();
          mem[p[15:8]] <= p[7:0];
        end
        busy_cnt <= BUSY_CYC;
        commits  <= commits + 1;
      end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_stop();  sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic bit_out(input logic b); sda_m = b; wq(); scl = 1; wq(); wq(); scl = 0; wq(); endtask
  task automatic bit_in(output logic b); sda_m = 1; wq(); scl = 1; wq(); b = sda_line; wq(); scl = 0; wq(); endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    check(a == !exp_ack, tag, int'(a), int'(!exp_ack));
  endtask

  task automatic recv_byte(input logic mack, input string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    check(v == mem[eptr], tag, v, mem[eptr]);
    eptr = (eptr + 1) % 256;
    bit_out(!mack);
  endtask

  task automatic wait_idle(); while (wr_busy) @(negedge clk); wq(); endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d[$]);
    bus_start();
    send_byte(8'hA0, 1'b1, "R2 write address ack");
    send_byte(a, 1'b1, "R3 word address ack");
    eptr = a;
    foreach (d[i]) begin
      exp_q.push_back({8'(eptr), d[i]});
      send_byte(d[i], 1'b1, "R3 data ack");
      eptr = (eptr & 8'hF0) | ((eptr + 1) & 8'h0F);
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    bus_start();
    send_byte(8'hA0, 1'b1, "R7 dummy write ack");
    send_byte(a, 1'b1, "R7 word address ack");
    eptr = a;
    bus_start();
    send_byte(8'hA1, 1'b1, "R2 read address ack");
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, tag);
    bus_stop();
  endtask

  initial begin
    int c0;
    logic b;
    n_chk = 0; n_fail = 0; eptr = 0;
    scl = 1; sda_m = 1; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sda_oe == 0, "reset sda_oe", sda_oe, 0);
    check(wr_push == 0 && wr_commit == 0, "reset strobes", {wr_push, wr_commit}, 0);
    check(mem_raddr == 0, "R6 pointer reset", mem_raddr, 0);

    // R6 current-address reads, R11 release after master nack
    bus_start();
    send_byte(8'hA1, 1'b1, "R2 read ack");
    recv_byte(1'b0, "R6 current read at 0");
    bit_in(b); check(b == 1, "R11 released after nack", b, 1);
    bit_in(b); check(b == 1, "R11 still released", b, 1);
    bus_stop();
    bus_start();
    send_byte(8'hA1, 1'b1, "R2 read ack");
    recv_byte(1'b0, "R6 current read at 1");
    bus_stop();

    // R1 byte without START ignored
    send_byte(8'hA0, 1'b0, "R1 no start no ack");
    bus_stop();

    // R10 mismatch stays silent
    bus_start();
    send_byte(8'hA2, 1'b0, "R10 mismatch no ack");
    send_byte(8'h00, 1'b0, "R10 silent after mismatch");
    bus_stop();

    // R5 R9 byte write and commit
    c0 = commits;
    do_write(8'h40, '{8'h5A});
    repeat (4) @(negedge clk);
    check(commits == c0 + 1, "R9 commit after write", commits, c0 + 1);
    check(exp_q.size() == 0, "R5 all pushes seen", exp_q.size(), 0);

    // R4 busy polling
    bus_start();
    send_byte(8'hA0, 1'b0, "R4 busy no ack");
    bus_stop();
    wait_idle();
    c0 = commits;
    bus_start();
    send_byte(8'hA0, 1'b1, "R4 ack after busy");
    bus_stop();
    repeat (4) @(negedge clk);
    check(commits == c0, "R9 no commit without data", commits, c0);

    // R7 random read, R8 continuing
    rand_read(8'h40, 2, "R7 random read");

    // R9 page wrap
    do_write(8'h1E, '{8'hC1, 8'hC2, 8'hC3});
    wait_idle();
    check(exp_q.size() == 0, "R9 page pushes seen", exp_q.size(), 0);
    bus_start();
    send_byte(8'hA1, 1'b1, "R2 read ack");
    recv_byte(1'b0, "R6 current read after page write");
    bus_stop();

    // R8 full-array wrap
    rand_read(8'hFE, 4, "R8 sequential wrap");

    // R12 abort mid-byte then random read of wrapped page byte
    bus_start();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    rand_read(8'h10, 1, "R12 read after abort");
    check(mem[8'h10] == 8'hC3, "R9 page wrap target", mem[8'h10], 8'hC3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule